// File: doc/BRIEF.md
# Parallel-Prefix Tree Adder

This block is a purely combinational adder of two `WIDTH`-bit operands and a carry input. It produces a `WIDTH`-bit sum and a carry output. `WIDTH` must be a power of two and defaults to 16.

Each operand bit pair is first reduced to a bitwise generate and propagate. The carry input is treated as an extra position below bit 0. A logarithmic-depth network then combines these into the group generate from every bit down to that carry position. The sum is the bitwise propagate XOR the group generate one position lower.

The elaboration-time parameter `TOPO` selects how the network is wired:
- a minimum-cell up-sweep/down-sweep tree;
- a divide-and-conquer tree in which each half block fans out from the top of its lower half;
- a full-span tree in which level `s` merges each position with the one `2^(s-1)` lower.

The block is used wherever a wide single-cycle addition must meet a short critical path. The topology is picked per instance to trade cell count, fan-out and depth.

Top module: `tree_adder`

## Requirements
- R1: For every operand pair and carry input, `{cout_o, s_o}` equals `a_i + b_i + cin_i` taken as a `WIDTH+1`-bit unsigned sum, for each of the three `TOPO` values.
- R2: With both operands zero, `s_o` equals `cin_i` zero-extended and `cout_o` is 0, so the carry input acts as the generate of the position below bit 0.
- R3: When every bit propagates (`a_i ^ b_i` all ones), the result depends only on the carry input. With carry in 1, `s_o` is all zeros and `cout_o` is 1. With carry in 0, `s_o` is all ones and `cout_o` is 0.
- R4: When both operands have their most significant bit set, `cout_o` is 1 whatever the lower bits and the carry input are.
- R5: When neither operand has its most significant bit set, `cout_o` is 0.
- R6: The three topologies (`TOPO` = `TOPO_MIN_CELL`, `TOPO_HALF_FANOUT`, `TOPO_FULL_SPAN`) give identical `s_o` and `cout_o` for identical inputs.
- R7: For each position `k`, the network's group generate equals the carry that a bit-serial ripple would deliver into sum bit `k`. After the last level, every network node spans down to the carry position, so its group propagate is 0.
- R8: The network uses log2(`WIDTH`) levels for the half-fanout and full-span topologies, and 2·log2(`WIDTH`)−1 levels for the minimum-cell topology.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First addend |
| b_i | input | WIDTH | Second addend |
| cin_i | input | 1 | Carry into bit 0 |
| s_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The immediate assertions check, on every input change, several properties of the settled outputs:
- the arithmetic identity;
- the carry-only cases with zero or all-propagate operands;
- the forced carry-out and no carry-out cases set by the top operand bits;
- inside the network, that each group generate matches a ripple recomputation and that every final group propagate is zero.

Two behaviours are visible only from the bench's scenarios. The first is that all three wirings agree with each other; the bench runs one instance of each side by side. The second is that a carry is delivered correctly into each individual bit position; the bench drives a directed walk of lengthening carry chains.

// File: rtl/tree_adder_pkg.sv
package tree_adder_pkg;

  typedef enum logic [1:0] {
    TOPO_MIN_CELL    = 2'd0,
    TOPO_HALF_FANOUT = 2'd1,
    TOPO_FULL_SPAN   = 2'd2
  } topo_e;

  // Number of network levels for a topology (R8)
  function automatic int pfx_levels(topo_e t, int n);
    int lg;
    lg = $clog2(n);
    if (t == TOPO_MIN_CELL) return (lg > 1) ? 2 * lg - 1 : lg;
    return lg;
  endfunction

  // Lower partner combined into node i at level lvl, -1 means pass-through
  function automatic int pfx_partner(topo_e t, int n, int lvl, int i);
    int lg, d, h, m;
    lg = $clog2(n);
    case (t)
      TOPO_FULL_SPAN: begin
        if (lvl <= lg) begin
          d = 1 << (lvl - 1);
          if (i >= d) return i - d;
        end
      end
      TOPO_HALF_FANOUT: begin
        if (lvl <= lg) begin
          d = 1 << lvl;
          h = d >> 1;
          if ((i % d) >= h) return (i / d) * d + h - 1;
        end
      end
      default: begin
        if (lvl <= lg) begin
          d = 1 << lvl;
          if (((i + 1) % d) == 0) return i - (d >> 1);
        end else if (lvl <= 2 * lg - 1) begin
          m = 2 * lg - lvl;
          d = 1 << m;
          h = d >> 1;
          if ((((i + 1) % d) == h) && (i >= d)) return i - h;
        end
      end
    endcase
    return -1;
  endfunction

  // Lowest position covered by node i after level lvl
  function automatic int pfx_span_lo(topo_e t, int n, int lvl, int i);
    int cur, pj;
    cur = i;
    for (int k = lvl; k >= 1; k--) begin
      pj = pfx_partner(t, n, k, cur);
      if (pj >= 0) cur = pj;
    end
    return cur;
  endfunction

endpackage

// File: rtl/pfx_black_cell.sv
module pfx_black_cell (
  input  logic g_hi_i,
  input  logic p_hi_i,
  input  logic g_lo_i,
  input  logic p_lo_i,
  output logic g_o,
  output logic p_o
);
  assign g_o = g_hi_i | (p_hi_i & g_lo_i);
  assign p_o = p_hi_i & p_lo_i;
endmodule

// File: rtl/pfx_gray_cell.sv
module pfx_gray_cell (
  input  logic g_hi_i,
  input  logic p_hi_i,
  input  logic g_lo_i,
  output logic g_o
);
  assign g_o = g_hi_i | (p_hi_i & g_lo_i);
endmodule

// File: rtl/tree_adder_pg.sv
module tree_adder_pg #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH:0]   g_o,
  output logic [WIDTH:0]   p_o
);
  // position 0 carries the carry input; operand bit k sits at position k+1
  assign g_o = {a_i & b_i, cin_i};
  assign p_o = {a_i ^ b_i, 1'b0};
endmodule

// File: rtl/tree_adder_net.sv
module tree_adder_net
  import tree_adder_pkg::*;
#(
  parameter int    WIDTH = 16,
  parameter topo_e TOPO  = TOPO_MIN_CELL
) (
  input  logic [WIDTH-1:0] g_i,
  input  logic [WIDTH-1:0] p_i,
  output logic [WIDTH-1:0] gpre_o
);
  localparam int LVLS = pfx_levels(TOPO, WIDTH);

  logic [WIDTH-1:0] g_l [0:LVLS];
  logic [WIDTH-1:0] p_l [0:LVLS];

  assign g_l[0] = g_i;
  assign p_l[0] = p_i;

  for (genvar l = 1; l <= LVLS; l++) begin : g_lvl
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      localparam int PJ = pfx_partner(TOPO, WIDTH, l, i);
      if (PJ < 0) begin : g_buf
        assign g_l[l][i] = g_l[l-1][i];
        assign p_l[l][i] = p_l[l-1][i];
      end else if (pfx_span_lo(TOPO, WIDTH, l - 1, PJ) == 0) begin : g_gray
        pfx_gray_cell u_cell (
          .g_hi_i (g_l[l-1][i]),
          .p_hi_i (p_l[l-1][i]),
          .g_lo_i (g_l[l-1][PJ]),
          .g_o    (g_l[l][i])
        );
        assign p_l[l][i] = 1'b0;  // span includes the carry slot, P is 0
      end else begin : g_black
        pfx_black_cell u_cell (
          .g_hi_i (g_l[l-1][i]),
          .p_hi_i (p_l[l-1][i]),
          .g_lo_i (g_l[l-1][PJ]),
          .p_lo_i (p_l[l-1][PJ]),
          .g_o    (g_l[l][i]),
          .p_o    (p_l[l][i])
        );
      end
    end
  end

  assign gpre_o = g_l[LVLS];

  always_comb begin
    logic c;
    logic ok;
    c  = 1'b0;
    ok = 1'b1;
    for (int k = 0; k < WIDTH; k++) begin
      c = g_i[k] | (p_i[k] & c);
      if (gpre_o[k] !== c) ok = 1'b0;
    end
    assert_prefix_ripple_R7 : assert (ok || $isunknown({g_i, p_i}))
      else $error("prefix generate differs from ripple carry");
    assert_full_span_R7 : assert (p_l[LVLS] == '0 || $isunknown(p_i))
      else $error("final node does not reach carry slot");
  end

  initial begin
    assert_levels_R8 : assert (LVLS == ((TOPO == TOPO_MIN_CELL && WIDTH > 2)
                                        ? 2 * $clog2(WIDTH) - 1 : $clog2(WIDTH)))
      else $error("unexpected level count");
  end
endmodule

// File: rtl/tree_adder_sum.sv
module tree_adder_sum #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] p_i,
  input  logic [WIDTH-1:0] gpre_i,
  input  logic             g_top_i,
  output logic [WIDTH-1:0] s_o,
  output logic             cout_o
);
  assign s_o    = p_i ^ gpre_i;
  assign cout_o = g_top_i | (p_i[WIDTH-1] & gpre_i[WIDTH-1]);
endmodule

// File: rtl/tree_adder.sv
module tree_adder
  import tree_adder_pkg::*;
#(
  parameter int    WIDTH = 16,
  parameter topo_e TOPO  = TOPO_MIN_CELL
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] s_o,
  output logic             cout_o
);
  logic [WIDTH:0]   g_bit;
  logic [WIDTH:0]   p_bit;
  logic [WIDTH-1:0] gpre;

  initial begin
    assert_pow2_width : assert (WIDTH >= 2 && (WIDTH & (WIDTH - 1)) == 0)
      else $error("WIDTH must be a power of two");
  end

  tree_adder_pg #(.WIDTH(WIDTH)) u_pg (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (cin_i),
    .g_o   (g_bit),
    .p_o   (p_bit)
  );

  tree_adder_net #(.WIDTH(WIDTH), .TOPO(TOPO)) u_net (
    .g_i    (g_bit[WIDTH-1:0]),
    .p_i    (p_bit[WIDTH-1:0]),
    .gpre_o (gpre)
  );

  tree_adder_sum #(.WIDTH(WIDTH)) u_sum (
    .p_i     (p_bit[WIDTH:1]),
    .gpre_i  (gpre),
    .g_top_i (g_bit[WIDTH]),
    .s_o     (s_o),
    .cout_o  (cout_o)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      assert_sum_R1 : assert ({cout_o, s_o} == {1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i))
        else $error("sum mismatch");
      if (a_i == '0 && b_i == '0) begin
        assert_cin_slot_R2 : assert (s_o == WIDTH'(cin_i) && !cout_o)
          else $error("carry input not at bit 0");
      end
      if ((a_i ^ b_i) == '1) begin
        assert_all_prop_R3 : assert (s_o == {WIDTH{~cin_i}} && cout_o == cin_i)
          else $error("propagate chain wrong");
      end
      if (a_i[WIDTH-1] && b_i[WIDTH-1]) begin
        assert_top_gen_R4 : assert (cout_o) else $error("top generate lost");
      end
      if (!a_i[WIDTH-1] && !b_i[WIDTH-1]) begin
        assert_top_kill_R5 : assert (!cout_o) else $error("carry out not killed");
      end
    end
  end
endmodule

// File: tb/test_tree_adder.sv
`timescale 1ns/1ps
module test_tree_adder;
  import tree_adder_pkg::*;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic         cin;
  logic [W-1:0] s_mc, s_hf, s_fs;
  logic         co_mc, co_hf, co_fs;
  int           n_chk = 0;
  int           n_fail = 0;
  int           cyc = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  tree_adder #(.WIDTH(W), .TOPO(TOPO_MIN_CELL)) i_tree_adder (
    .a_i(a), .b_i(b), .cin_i(cin), .s_o(s_mc), .cout_o(co_mc));
  tree_adder #(.WIDTH(W), .TOPO(TOPO_HALF_FANOUT)) i_tree_adder_hf (
    .a_i(a), .b_i(b), .cin_i(cin), .s_o(s_hf), .cout_o(co_hf));
  tree_adder #(.WIDTH(W), .TOPO(TOPO_FULL_SPAN)) i_tree_adder_fs (
    .a_i(a), .b_i(b), .cin_i(cin), .s_o(s_fs), .cout_o(co_fs));

  task automatic chk(string req, string who, logic [W:0] act, logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: a=%h b=%h cin=%b actual=%h expected=%h", req, who, a, b, cin, act, exp);
    end
  endtask

  // drive after the edge, compare at the falling edge
  task automatic apply(logic [W-1:0] av, logic [W-1:0] bv, logic cv, string req);
    longint   ref_v;
    logic [W:0] exp;
    @(posedge clk);
    #1;
    a = av; b = bv; cin = cv;
    ref_v = longint'(av) + longint'(bv) + longint'(cv);
    exp   = ref_v[W:0];
    @(negedge clk);
    chk(req, "min_cell",    {co_mc, s_mc}, exp);
    chk(req, "half_fanout", {co_hf, s_hf}, exp);
    chk(req, "full_span",   {co_fs, s_fs}, exp);
    chk("R6", "agree", {co_hf, s_hf} ^ {co_fs, s_fs} ^ {co_mc, s_mc}, {co_mc, s_mc});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    // R2: idle state and carry slot
    apply('0, '0, 1'b0, "R2");
    apply('0, '0, 1'b1, "R2");
    // R3: full propagate chains
    apply('1, '0, 1'b1, "R3");
    apply('1, '0, 1'b0, "R3");
    apply(16'hA5C3, 16'h5A3C, 1'b1, "R3");
    apply(16'h0F0F, 16'hF0F0, 1'b0, "R3");
    // R4: top-bit generate
    apply(16'h8000, 16'h8000, 1'b0, "R4");
    apply('1, '1, 1'b1, "R4");
    // R5: top-bit kill
    apply(16'h7FFF, 16'h7FFF, 1'b1, "R5");
    apply(16'h0000, 16'h7FFF, 1'b1, "R5");
    // R7: carry delivered into each position
    for (int k = 0; k <= W; k++) begin
      logic [W:0] m;
      m = (17'd1 << k) - 17'd1;
      apply(m[W-1:0], '0, 1'b1, "R7");
      apply(m[W-1:0], 16'd1, 1'b0, "R7");
    end
    // R1: random operands
    for (int n = 0; n < 3000; n++) begin
      apply(W'($urandom), W'($urandom), 1'($urandom), "R1");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule